// File: doc/BRIEF.md
# Supply Voltage Monitor Status and Control Register

This block is an 8-bit software-visible register that sits beside an external supply-voltage comparator. The comparator delivers a detect signal that is already synchronous to the register clock. While the detector is enabled, the register latches each detect pulse into a sticky status flag. Software clears the flag by writing a one to a write-only acknowledge bit. The register also holds five enables: interrupt, system reset, operation in stop mode, the detector itself, and the bandgap reference buffer.

Three of these enables are safety controls: reset, stop-mode operation and detector enable. They come out of reset set to 1 and take only the first register write after reset. After that write they are frozen until the next reset. The interrupt enable and the bandgap buffer enable can be written at any time. The block drives an interrupt request from the flag and the interrupt enable. It also drives a system-reset request straight from the detect input, qualified by the detector enable and the reset enable. Software reaches the register through a simple write strobe with write data and a combinational read-data bus.

Top module: `vmon_ctrl_reg`

## Requirements
- R1: After reset the read data is 0x1C, interrupt request is 0, and the reset request is 0 while the detect input is 0.
- R2: Read bit 6 (acknowledge) and read bit 1 (reserved) always read 0, whatever was written to them.
- R3: When the detect input is 1 and the detector enable (bit 2) is 1 at a clock edge, the flag (bit 7) reads 1 from the next cycle and stays 1 until acknowledged.
- R4: While the detector enable is 0, the detect input never sets the flag.
- R5: A write with bit 6 = 1 clears the flag in the next cycle. A write with bit 6 = 0 leaves the flag unchanged.
- R6: If a detect event and an acknowledge write fall in the same cycle, the flag remains 1.
- R7: The first write after reset loads bit 4 (reset enable), bit 3 (stop enable) and bit 2 (detector enable). Every later write leaves those three bits unchanged until the next reset.
- R8: Bit 5 (interrupt enable) and bit 0 (bandgap buffer enable) take their written value on every write.
- R9: The interrupt request equals the flag ANDed with the interrupt enable.
- R10: The reset request is combinationally 1 exactly when the detect input, the detector enable and the reset enable are all 1.
- R11: Writing bit 7 has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| det_in | input | 1 | Synchronous low-voltage detect from the comparator |
| rd_data | output | 8 | Current register contents |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| stop_en_o | output | 1 | Detector stays active in stop mode |
| det_en_o | output | 1 | Detector enable to the analog block |
| bgbuf_en_o | output | 1 | Bandgap buffer enable |

## Verification
A stale write-once tracker can fail in two ways, and both show on rd_data one cycle after the write. If it is stuck open, a second write changes bits 4..2. If it is closed too early, the first write is dropped. A flag with the wrong priority between set and clear shows on bit 7 and on irq_o in the cycle after a combined detect and acknowledge. The reset request is combinational, so a wrong enable shows on rst_req_o within the same cycle as the detect input.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  localparam int REG_W    = 8;
  localparam int POS_FLAG = 7;
  localparam int POS_ACK  = 6;
  localparam int POS_IE   = 5;
  localparam int POS_RE   = 4;
  localparam int POS_SE   = 3;
  localparam int POS_DE   = 2;
  localparam int POS_RSV  = 1;
  localparam int POS_BG   = 0;

  // protected group ordering {reset en, stop en, detect en}
  localparam int ONCE_W = 3;
  localparam logic [ONCE_W-1:0] ONCE_RST = 3'b111;
  // free group ordering {irq en, bandgap en}
  localparam int FREE_W = 2;
  localparam logic [FREE_W-1:0] FREE_RST = 2'b00;

  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  function automatic logic [ONCE_W-1:0] once_of(input logic [REG_W-1:0] d);
    return {d[POS_RE], d[POS_SE], d[POS_DE]};
  endfunction

  function automatic logic [FREE_W-1:0] free_of(input logic [REG_W-1:0] d);
    return {d[POS_IE], d[POS_BG]};
  endfunction

  function automatic logic [REG_W-1:0] pack_read(input logic flag,
                                                 input logic [ONCE_W-1:0] prot,
                                                 input logic [FREE_W-1:0] free);
    logic [REG_W-1:0] r;
    r           = '0;
    r[POS_FLAG] = flag;
    r[POS_IE]   = free[1];
    r[POS_RE]   = prot[2];
    r[POS_SE]   = prot[1];
    r[POS_DE]   = prot[0];
    r[POS_BG]   = free[0];
    return r;
  endfunction

endpackage

// File: rtl/vmon_lock.sv
module vmon_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  output logic open_o,
  output logic first_wr_o
);
  logic used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used_q <= 1'b0;
    else if (wr_en) used_q <= 1'b1;
  end

  assign open_o     = ~used_q;
  assign first_wr_o = wr_en & ~used_q;
endmodule

// File: rtl/vmon_field.sv
module vmon_field #(
  parameter int              W    = 2,
  parameter logic [W-1:0]    RST  = '0,
  parameter bit              ONCE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         open_i,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic gate;
  logic load;

  assign gate = ONCE ? open_i : 1'b1;
  assign load = wr_en & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= wdata;
  end
endmodule

// File: rtl/vmon_flag.sv
module vmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic det_en_i,
  input  logic ack_i,
  output logic flag_q,
  output logic set_ev_o,
  output logic clr_ev_o
);
  import vmon_pkg::*;

  assign set_ev_o = det_i & det_en_i;
  assign clr_ev_o = ack_i & ~set_ev_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, set_ev_o, ack_i);
  end
endmodule

// File: rtl/vmon_ctrl_reg.sv
module vmon_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       det_in,
  output logic [7:0] rd_data,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       stop_en_o,
  output logic       det_en_o,
  output logic       bgbuf_en_o
);
  import vmon_pkg::*;

  // named internal events, visible to the checker
  logic                 lock_open;
  logic                 first_wr;
  logic                 ack_wr;
  logic                 det_ev;
  logic                 clr_ev;
  logic                 flag;
  logic [ONCE_W-1:0]    prot;
  logic [FREE_W-1:0]    free;
  logic                 ie;

  assign ack_wr = wr_en & wr_data[POS_ACK];

  vmon_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .open_o     (lock_open),
    .first_wr_o (first_wr)
  );

  vmon_field #(.W(ONCE_W), .RST(ONCE_RST), .ONCE(1'b1)) u_prot (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .open_i (lock_open),
    .wdata  (once_of(wr_data)),
    .q      (prot)
  );

  vmon_field #(.W(FREE_W), .RST(FREE_RST), .ONCE(1'b0)) u_free (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .open_i (1'b1),
    .wdata  (free_of(wr_data)),
    .q      (free)
  );

  vmon_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_i    (det_in),
    .det_en_i (prot[0]),
    .ack_i    (ack_wr),
    .flag_q   (flag),
    .set_ev_o (det_ev),
    .clr_ev_o (clr_ev)
  );

  assign ie         = free[1];
  assign rd_data    = pack_read(flag, prot, free);
  assign irq_o      = flag & ie;
  assign rst_req_o  = det_ev & prot[2];
  assign stop_en_o  = prot[1];
  assign det_en_o   = prot[0];
  assign bgbuf_en_o = free[0];
endmodule

// File: rtl/vmon_ctrl_reg_chk.sv
module vmon_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       ack_wr,
  input logic       det_ev,
  input logic       flag,
  input logic       ie,
  input logic [2:0] prot,
  input logic       lock_open,
  input logic       irq_o,
  input logic       rst_req_o
);
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    det_ev |=> flag);

  assert_flag_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !det_ev) |=> !flag);

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ack_wr && !det_ev) |=> !flag);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_ev && ack_wr) |=> flag);

  assert_lock_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !lock_open);

  assert_prot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_open |=> $stable(prot));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_ev && ie && !wr_en) |=> irq_o);

  assert_rst_req_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> det_ev);
endmodule

bind vmon_ctrl_reg vmon_ctrl_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .ack_wr    (ack_wr),
  .det_ev    (det_ev),
  .flag      (flag),
  .ie        (ie),
  .prot      (prot),
  .lock_open (lock_open),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o)
);

// File: tb/vmon_ctrl_reg_test.sv
module vmon_ctrl_reg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       det_in = 1'b0;
  logic [7:0] rd_data;
  logic       irq_o, rst_req_o, stop_en_o, det_en_o, bgbuf_en_o;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit m_flag, m_ie, m_re, m_se, m_de, m_bg, m_used;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmon_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .det_in(det_in),
    .rd_data(rd_data), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .stop_en_o(stop_en_o), .det_en_o(det_en_o), .bgbuf_en_o(bgbuf_en_o)
  );

  function automatic int model_read();
    int v;
    v = 0;
    if (m_flag) v += 128;
    if (m_ie)   v += 32;
    if (m_re)   v += 16;
    if (m_se)   v += 8;
    if (m_de)   v += 4;
    if (m_bg)   v += 1;
    return v;
  endfunction

  task automatic check(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check(int'(rd_data), model_read(), tag, "rd_data");
    check(int'(irq_o), (m_flag && m_ie) ? 1 : 0, tag, "irq_o");
    check(int'(rst_req_o), (det_in && m_de && m_re) ? 1 : 0, tag, "rst_req_o");
    check(int'({stop_en_o, det_en_o, bgbuf_en_o}),
          (m_se ? 4 : 0) + (m_de ? 2 : 0) + (m_bg ? 1 : 0), tag, "enables");
  endtask

  // drive one cycle, compare, then advance the model at the clock edge
  task automatic step(input bit w, input int d, input bit det, input string tag);
    bit set, ack;
    @(negedge clk);
    wr_en = w; wr_data = 8'(d); det_in = det;
    #1;
    compare_all(tag);
    @(posedge clk);
    set = det && m_de;
    ack = w && ((d / 64) % 2 == 1);
    if (set) m_flag = 1;
    else if (ack) m_flag = 0;
    if (w) begin
      if (!m_used) begin
        m_re = (d / 16) % 2 == 1;
        m_se = (d / 8) % 2 == 1;
        m_de = (d / 4) % 2 == 1;
      end
      m_used = 1;
      m_ie = (d / 32) % 2 == 1;
      m_bg = d % 2 == 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; wr_data = 0; det_in = 0;
    m_flag = 0; m_ie = 0; m_bg = 0; m_re = 1; m_se = 1; m_de = 1; m_used = 0;
    repeat (2) @(negedge clk);
    #1;
    check(int'(rd_data), 'h1C, "R1", "rd_data in reset");
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    step(0, 'h00, 0, "R1");
    check(int'(rd_data), 'h1C, "R1", "rd_data after reset");
    // first write clears the protected bits, later writes cannot restore them
    step(1, 'h00, 0, "R7");
    step(0, 'h00, 1, "R4");
    step(0, 'h00, 1, "R4");
    check(int'(rd_data[7]), 0, "R4", "flag with detector off");
    step(1, 'hFF, 1, "R7");
    step(0, 'h00, 0, "R8");
    check(int'(rd_data), 'h21, "R7", "rd_data after locked write");
    step(1, 'h00, 0, "R8");
    step(0, 'h00, 0, "R8");
    check(int'(rd_data), 'h00, "R8", "free bits rewritten");

    // second reset: keep protections, enable irq
    do_reset();
    step(1, 'h3C, 0, "R7");
    step(0, 'h00, 1, "R10");
    check(int'(rst_req_o), 1, "R10", "reset request with detect");
    step(0, 'h00, 0, "R3");
    check(int'(rd_data), 'hBC, "R3", "flag set");
    check(int'(irq_o), 1, "R9", "irq with flag and enable");
    step(1, 'h3C, 0, "R5");
    step(0, 'h00, 0, "R5");
    check(int'(rd_data[7]), 1, "R5", "flag kept without ack");
    step(1, 'h7C, 1, "R6");
    step(0, 'h00, 0, "R6");
    check(int'(rd_data[7]), 1, "R6", "set wins over ack");
    step(1, 'h7E, 0, "R5");
    step(0, 'h00, 0, "R2");
    check(int'(rd_data), 'h3C, "R5", "flag cleared, reserved reads 0");
    check(int'(rd_data[6]) + int'(rd_data[1]), 0, "R2", "ack and reserved read 0");
    step(1, 'hBC, 0, "R11");
    step(0, 'h00, 0, "R11");
    check(int'(rd_data[7]), 0, "R11", "bit 7 write ignored");
    step(1, 'h80, 0, "R9");
    step(0, 'h00, 1, "R9");
    step(0, 'h00, 0, "R9");
    check(int'(irq_o), 0, "R9", "no irq with enable off");
    check(int'(rd_data), 'h9C, "R9", "flag set while polled");
    step(1, 'h61, 0, "R8");
    step(0, 'h00, 0, "R8");
    check(int'(rd_data), 'h3D, "R8", "irq and bandgap enables loaded");
    step(0, 'h00, 0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule